// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a general-purpose I/O controller for a pin count that is a multiple of 32 (64 by default). Software reaches it through a simple 32-bit register bus with a combinational read path: on a cycle with `bus_sel` high and `bus_wr` low, `bus_rdata` shows the addressed word. A write is taken on the rising clock edge while `bus_sel` and `bus_wr` are both high. Every register kind owns a bank of consecutive words. The only exception is the alternate-function bank, which packs two bits per pin and so needs twice as many words.

For each pin the controller holds a direction bit, an output level, enables for rising and falling edges, a sticky edge-status bit and a 2-bit alternate-function code. Output levels change only through separate set and clear registers. A write of ones touches only the selected pins, so no read-modify-write is needed. Pin inputs go through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. A single interrupt line is high while any status bit is set.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: With nreg = NUM_PINS/32, word r of register kind t sits at byte address t*nreg*4 + r*4, and pin p uses bit p%32 of word p/32. The kinds in address order are: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function. The alternate-function bank has 2*nreg words. Any word beyond it reads 0, and a write to it is ignored.
- R2: After reset every register, `pin_out`, `pin_oe` and `irq` are 0.
- R3: The level register returns the pin input two clock edges after the pin changes. Writes to the level register have no effect.
- R4: A direction bit of 1 enables the pin's output driver (`pin_oe`), and 0 makes the pin an input.
- R5: Writing 1 to a bit of the set register drives that pin's `pin_out` high on the next edge. Writing 1 to a bit of the clear register drives it low. Zero bits leave the pin unchanged. Both registers read as 0.
- R6: A rising enable of 1 lets a synchronized low-to-high transition set the pin's status bit, and a falling enable of 1 does the same for high-to-low. With both enables set, either edge sets the bit. With neither set, no transition changes the status bit.
- R7: Status bits are sticky. Writing 1 to a status bit clears only that bit. An edge captured in the same cycle as the clearing write leaves the bit set.
- R8: `irq` is high exactly while any status bit in any bank is set.
- R9: Pin p's alternate-function code lies in word p/16 of the alternate-function bank, at bits 2*(p%16)+1 down to 2*(p%16). Code 0 selects plain GPIO, and any non-zero code forces `pin_oe` low whatever the direction bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Pin output levels |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Combined edge interrupt |

## Verification
The embedded assertions check on every cycle that:
- set and clear writes reach `pin_out` on the next edge;
- a pin with both edge enables off never gains a status bit;
- a set status bit survives unless its clear bit was written;
- a captured edge always lands in status, even against a simultaneous clear;
- `irq` rises only after a real captured edge.

Only the bench's scenarios can show the following:
- the address map, with its per-kind banks, the double-width alternate-function bank and the unmapped words;
- the two-edge latency of the level register;
- the alternate-function gating of `pin_oe`;
- the race between an edge and a clear, placed in one exact cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int WORD_W = 32;
    localparam int AF_W   = 2;
    localparam int NKINDS_PLAIN = 7;

    typedef enum logic [2:0] {
        RK_LEVEL = 3'd0,
        RK_DIR   = 3'd1,
        RK_SET   = 3'd2,
        RK_CLR   = 3'd3,
        RK_RISE  = 3'd4,
        RK_FALL  = 3'd5,
        RK_STAT  = 3'd6,
        RK_ALTF  = 3'd7
    } reg_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int NREG   = 2,
    parameter int ADDR_W = 7,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    localparam int WORD_AW = ADDR_W - 2;

    logic [WORD_AW-1:0] word;
    int                 wi;

    assign word = addr[ADDR_W-1:2];

    // Banks are consecutive; kind 7 holds twice as many words (R1)
    always_comb begin
        wi   = int'(word);
        kind = RK_LEVEL;
        idx  = '0;
        hit  = 1'b0;
        for (int t = 0; t < NKINDS_PLAIN; t++) begin
            if (wi >= t*NREG && wi < (t+1)*NREG) begin
                kind = reg_kind_e'(t);
                idx  = IDX_W'(wi - t*NREG);
                hit  = 1'b1;
            end
        end
        if (wi >= NKINDS_PLAIN*NREG && wi < (NKINDS_PLAIN+2)*NREG) begin
            kind = RK_ALTF;
            idx  = IDX_W'(wi - NKINDS_PLAIN*NREG);
            hit  = 1'b1;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = async_in;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level = sync_q.s2;
    assign rise  = sync_q.s2 & ~sync_q.prev;
    assign fall  = ~sync_q.s2 & sync_q.prev;

    // R3: the synchronized level lags its first stage by exactly one edge
    assert_level_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (level == $past(sync_q.s1)));
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = $clog2(9 * (NUM_PINS / 32) * 4)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NREG    = NUM_PINS / WORD_W;
    localparam int AF_BITS = NUM_PINS * AF_W;
    localparam int IDX_W   = $clog2(2 * NREG);

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] out;
        logic [NUM_PINS-1:0] rise_en;
        logic [NUM_PINS-1:0] fall_en;
        logic [NUM_PINS-1:0] sts;
        logic [AF_BITS-1:0]  af;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    reg_kind_e           kind;
    logic [IDX_W-1:0]    idx;
    logic                addr_hit;
    logic [NUM_PINS-1:0] lvl, rise, fall;
    int                  shamt;
    logic                wr_go;
    logic [NUM_PINS-1:0] pin_m, pin_w;
    logic [AF_BITS-1:0]  af_m, af_w;
    logic [NUM_PINS-1:0] set_m, clr_m, stclr_m, edge_hit;

    gpio_addr_decode #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx),
        .hit  (addr_hit)
    );

    gpio_in_sync #(.W(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .level    (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    assign shamt = WORD_W * int'(idx);

    // Next-state computation
    always_comb begin
        wr_go    = bus_sel & bus_wr & addr_hit;
        pin_m    = NUM_PINS'({WORD_W{1'b1}}) << shamt;
        af_m     = AF_BITS'({WORD_W{1'b1}}) << shamt;
        pin_w    = {NREG{bus_wdata}};
        af_w     = {(2*NREG){bus_wdata}};
        set_m    = (wr_go && kind == RK_SET)  ? (pin_w & pin_m) : '0;
        clr_m    = (wr_go && kind == RK_CLR)  ? (pin_w & pin_m) : '0;
        stclr_m  = (wr_go && kind == RK_STAT) ? (pin_w & pin_m) : '0;
        edge_hit = (rise & ctrl_q.rise_en) | (fall & ctrl_q.fall_en);

        ctrl_d = ctrl_q;
        if (wr_go) begin
            case (kind)
                RK_DIR:  ctrl_d.dir     = (ctrl_q.dir & ~pin_m) | (pin_w & pin_m);
                RK_RISE: ctrl_d.rise_en = (ctrl_q.rise_en & ~pin_m) | (pin_w & pin_m);
                RK_FALL: ctrl_d.fall_en = (ctrl_q.fall_en & ~pin_m) | (pin_w & pin_m);
                RK_ALTF: ctrl_d.af      = (ctrl_q.af & ~af_m) | (af_w & af_m);
                default: ;
            endcase
        end
        ctrl_d.out = (ctrl_q.out | set_m) & ~clr_m;
        // Capture wins over the clear so no edge is lost
        ctrl_d.sts = (ctrl_q.sts & ~stclr_m) | edge_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // Read path
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && addr_hit) begin
            case (kind)
                RK_LEVEL: bus_rdata = 32'(lvl >> shamt);
                RK_DIR:   bus_rdata = 32'(ctrl_q.dir >> shamt);
                RK_RISE:  bus_rdata = 32'(ctrl_q.rise_en >> shamt);
                RK_FALL:  bus_rdata = 32'(ctrl_q.fall_en >> shamt);
                RK_STAT:  bus_rdata = 32'(ctrl_q.sts >> shamt);
                RK_ALTF:  bus_rdata = 32'(ctrl_q.af >> shamt);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // Output enables: direction gated by a plain-GPIO function code
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
        assign pin_oe[p] = ctrl_q.dir[p] & ~(|ctrl_q.af[AF_W*p +: AF_W]);
    end

    assign pin_out = ctrl_q.out;
    assign irq     = |ctrl_q.sts;

    // R5: set bits appear high on the pins one edge after the write
    assert_set_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m != '0) |=> ((pin_out & $past(set_m)) == $past(set_m)));

    // R5: clear bits appear low on the pins one edge after the write
    assert_clr_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_m != '0) |=> ((pin_out & $past(clr_m)) == '0));

    // R6: a pin with both edge enables off gains no status bit
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ctrl_q.sts & ~$past(ctrl_q.sts)
                   & ~$past(ctrl_q.rise_en | ctrl_q.fall_en)) == '0));

    // R7: status bits persist unless their clear bit was written
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ctrl_q.sts & $past(ctrl_q.sts & ~stclr_m))
                  == $past(ctrl_q.sts & ~stclr_m)));

    // R7: a captured edge always lands, even against a clearing write
    assert_edge_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((ctrl_q.sts & $past(edge_hit)) == $past(edge_hit)));

    // R8: the interrupt only rises after an enabled edge was seen
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(edge_hit) != '0));
endmodule

// File: tb/gpio_banked_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_banked_ctrl_tb;
    localparam int NUM_PINS = 64;
    localparam int ADDR_W   = 7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_sel = 1'b0;
    logic                bus_wr = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NUM_PINS-1:0] pin_in = '0;
    logic [NUM_PINS-1:0] pin_out, pin_oe;
    logic                irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    gpio_banked_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Write, then read back the same address
    typedef struct packed {
        logic [6:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_v;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{7'h08, 32'hFFFF_0000, 32'hFFFF_0000, 4'd1},  // direction word 0
        '{7'h0C, 32'h0000_8001, 32'h0000_8001, 4'd1},  // direction word 1
        '{7'h20, 32'h1234_5678, 32'h1234_5678, 4'd1},  // rising enable word 0
        '{7'h24, 32'h8765_4321, 32'h8765_4321, 4'd1},  // rising enable word 1
        '{7'h28, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 4'd1},  // falling enable word 0
        '{7'h2C, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 4'd1},  // falling enable word 1
        '{7'h38, 32'hC000_0001, 32'hC000_0001, 4'd9},  // alt function word 0
        '{7'h44, 32'h3000_0000, 32'h3000_0000, 4'd9},  // alt function word 3
        '{7'h10, 32'hFFFF_FFFF, 32'h0000_0000, 4'd5},  // set reads 0
        '{7'h1C, 32'hFFFF_FFFF, 32'h0000_0000, 4'd5},  // clear reads 0
        '{7'h00, 32'hFFFF_FFFF, 32'h0000_0000, 4'd3},  // level ignores writes
        '{7'h48, 32'hFFFF_FFFF, 32'h0000_0000, 4'd1}   // unmapped word
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
        chk(req, {32'h0, d}, {32'h0, exp});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(4.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2: all registers and outputs clear after reset
        for (int w = 0; w < 18; w++) chk_rd("R2 reset reg", 7'(w*4), 32'h0);
        chk("R2 pin_out", pin_out, 64'h0);
        chk("R2 pin_oe", pin_oe, 64'h0);
        chk("R2 irq", {63'h0, irq}, 64'h0);

        // R1 and others: table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].addr, VECS[i].wdata);
            chk_rd($sformatf("R%0d table vector %0d", VECS[i].req, i),
                   VECS[i].addr, VECS[i].exp_v);
        end
        // R1: word 2 of alt function is untouched by the other alt writes
        chk_rd("R1 alt word 2", 7'h40, 32'h0);

        do_reset();

        // R5: set and clear act on the selected pins only
        wr(7'h14, 32'h8000_0001);
        chk("R5 set", pin_out, 64'h8000_0001_0000_0000);
        wr(7'h1C, 32'h0000_0001);
        chk("R5 clear", pin_out, 64'h8000_0000_0000_0000);
        wr(7'h10, 32'h0000_0000);
        chk("R5 zero set", pin_out, 64'h8000_0000_0000_0000);

        // R4 direction drives output enable
        wr(7'h08, 32'h0000_0003);
        chk("R4 oe", pin_oe, 64'h3);
        // R9: pin 1 code 01 at bits 3:2 of alt word 0 gates its enable
        wr(7'h38, 32'h0000_0004);
        chk("R9 oe gated pin1", pin_oe, 64'h1);
        // R9: pin 63 lives in alt word 3 bits 31:30
        wr(7'h0C, 32'h8000_0000);
        chk("R9 oe pin63 plain", pin_oe, 64'h8000_0000_0000_0001);
        wr(7'h44, 32'hC000_0000);
        chk("R9 oe pin63 gated", pin_oe, 64'h1);

        // R3: level appears after two edges
        pin_in[40] = 1'b1;
        @(negedge clk);
        chk_rd("R3 level after one edge", 7'h04, 32'h0);
        @(negedge clk);
        chk_rd("R3 level after two edges", 7'h04, 32'h0000_0100);

        // R6: rise on pins 4,6; fall on pins 5,6; pin 7 disabled
        wr(7'h20, 32'h0000_0050);
        wr(7'h28, 32'h0000_0060);
        pin_in[7:4] = 4'hF;
        repeat (3) @(negedge clk);
        chk_rd("R6 rising capture", 7'h30, 32'h0000_0050);
        chk("R8 irq set", {63'h0, irq}, 64'h1);
        wr(7'h30, 32'h0000_0050);
        chk_rd("R7 w1c all", 7'h30, 32'h0);
        chk("R8 irq clear", {63'h0, irq}, 64'h0);
        pin_in[7:4] = 4'h0;
        repeat (3) @(negedge clk);
        chk_rd("R6 falling capture", 7'h30, 32'h0000_0060);
        wr(7'h30, 32'h0000_0020);
        chk_rd("R7 w1c one bit", 7'h30, 32'h0000_0040);

        // R7: edge on pin 6 captured in the very cycle its clear is written
        pin_in[6] = 1'b1;
        repeat (2) @(negedge clk);
        wr(7'h30, 32'h0000_0040);
        chk_rd("R7 edge beats clear", 7'h30, 32'h0000_0040);
        wr(7'h30, 32'h0000_0040);
        chk_rd("R7 cleared after race", 7'h30, 32'h0);

        // R8: an edge in bank 1 alone raises the interrupt
        wr(7'h24, 32'h0004_0000);
        pin_in[50] = 1'b1;
        repeat (3) @(negedge clk);
        chk_rd("R8 bank1 status", 7'h34, 32'h0004_0000);
        chk_rd("R8 bank0 quiet", 7'h30, 32'h0);
        chk("R8 irq bank1", {63'h0, irq}, 64'h1);
        wr(7'h34, 32'h0004_0000);
        chk("R8 irq after clear", {63'h0, irq}, 64'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule